// File: doc/BRIEF.md
# Interruptible Repeated Byte-Copy Sequencer

This block moves a run of bytes from one address range to another, one byte per iteration, through a simple request/valid memory port. Software, or the surrounding pipeline, hands it three architectural values: a source pointer, a destination pointer and a remaining count. Each iteration reads one byte at the source pointer and writes it to the destination pointer. Once both accesses are acknowledged, the block commits the advanced pointers and the decremented count to its architectural registers.

The copy can be preempted at any element boundary. A pending interrupt, or a raised single-step flag, makes the engine stop after the element in progress commits. It then reports an interrupted pulse while the committed pointer and count values sit on its outputs. Feeding those values back with a new start finishes only what is left. A count of zero ends the operation with a done pulse.

Top module: `rep_copy_engine`

## Requirements
- R1: After reset, `busy`, `mem_req`, `done` and `intr` are low.
- R2: Each element is a read request (`mem_we`=0) at the current source pointer, followed by a write request (`mem_we`=1) at the current destination pointer. The write carries the byte returned by the read.
- R3: On the cycle a write is acknowledged by `mem_valid`, the source and destination pointers each advance by one and the count drops by one. The registers change at no other time while busy.
- R4: When the count reaches zero, `done` is high for exactly one cycle, starting the cycle after the last write is acknowledged, with the final register values on the outputs.
- R5: A start with a count of zero raises `done` on the next cycle with no memory request, and the outputs equal the values given at start.
- R6: An `irq_req` pulse seen during a read/write pair is held until that pair commits. The engine then stops, with `intr` high for one cycle and the committed registers on the outputs.
- R7: While `single_step` is high, the engine stops with `intr` after every element that does not end the copy.
- R8: When the element that brings the count to zero completes, `done` is reported rather than `intr`, even if a stop is pending.
- R9: Restarting with the pointer and count values reported at a stop copies only the remaining elements, and ends with the same memory contents as an uninterrupted copy.
- R10: `irq_req` while idle is ignored, and every start with a nonzero count moves at least one element before it can stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a copy with the given registers (honoured while idle) |
| in_src | input | AW | Source pointer at start |
| in_dst | input | AW | Destination pointer at start |
| in_cnt | input | CW | Remaining element count at start |
| single_step | input | 1 | Stop after every element |
| irq_req | input | 1 | Interrupt request, any width of pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Access address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte returned by a read |
| mem_valid | input | 1 | Current access is complete |
| busy | output | 1 | A read or write phase is in progress |
| done | output | 1 | One-cycle pulse: copy finished |
| intr | output | 1 | One-cycle pulse: copy stopped at a boundary |
| out_src | output | AW | Architectural source pointer |
| out_dst | output | AW | Architectural destination pointer |
| out_cnt | output | CW | Architectural remaining count |

## Verification
The first read request appears one cycle after the start edge. The `done` or `intr` pulse rises one cycle after the edge that accepts the final write, and the committed registers are already on the outputs in that cycle. A zero-count start gives `done` one cycle after the start edge. The bench drives all inputs and the memory responses on the falling edge and samples outputs there. It waits for whichever pulse arrives and reads pointers, count and destination memory in that same half cycle. It then checks on the following falling edge that the pulse has fallen.

// File: rtl/rcopy_pkg.sv
// Package: shared state encoding for the repeated byte-copy sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package rcopy_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_WRITE = 3'd2,
        ST_DONE  = 3'd3,
        ST_STOP  = 3'd4
    } rcopy_state_e;

endpackage

// File: rtl/rcopy_arch_regs.sv
// Module: architectural pointer/count registers.
// Loads all three values on a start and advances them on each element commit.
// Assumes: load and commit are never high together.
module rcopy_arch_regs #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          commit,
    input  logic [AW-1:0] ld_src,
    input  logic [AW-1:0] ld_dst,
    input  logic [CW-1:0] ld_cnt,
    output logic [AW-1:0] cur_src,
    output logic [AW-1:0] cur_dst,
    output logic [CW-1:0] cur_cnt,
    output logic          ld_cnt_zero,
    output logic          last_elem
);
    localparam logic [AW-1:0] PTR_STEP = AW'(1);
    localparam logic [CW-1:0] CNT_STEP = CW'(1);

    // Register update: load at start, advance on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_src <= '0;
            cur_dst <= '0;
            cur_cnt <= '0;
        end else if (load) begin
            cur_src <= ld_src;
            cur_dst <= ld_dst;
            cur_cnt <= ld_cnt;
        end else if (commit) begin
            cur_src <= cur_src + PTR_STEP;
            cur_dst <= cur_dst + PTR_STEP;
            cur_cnt <= cur_cnt - CNT_STEP;
        end
    end

    // Count decodes used by the sequencer.
    always_comb begin
        ld_cnt_zero = (ld_cnt == '0);
        last_elem   = (cur_cnt == CNT_STEP);
    end
endmodule

// File: rtl/rcopy_irq_latch.sv
// Module: holds an interrupt request seen while an element is in flight.
// Assumes: requests while idle are not the engine's concern and are dropped.
module rcopy_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req,
    input  logic in_flight,
    input  logic clear,
    output logic pend_any
);
    logic pend_q;

    // Capture requests during a pair and drop them once a stop or finish is reported.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (clear)
            pend_q <= 1'b0;
        else if (in_flight && irq_req)
            pend_q <= 1'b1;
    end

    // A request in the commit cycle itself also counts.
    always_comb pend_any = pend_q | (in_flight & irq_req);
endmodule

// File: rtl/rcopy_fsm.sv
// Module: iteration sequencer for the byte copy.
// Walks idle -> read -> write per element and decides at each element boundary
// whether to finish, stop or continue.
// Assumes: mem_valid is a single-cycle acknowledge of the current request.
module rcopy_fsm
    import rcopy_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         ld_cnt_zero,
    input  logic         last_elem,
    input  logic         mem_valid,
    input  logic         stop_pend,
    input  logic         single_step,
    output rcopy_state_e state,
    output logic         load,
    output logic         capture,
    output logic         commit
);
    rcopy_state_e state_nx;

    // Next-state and strobe decode.
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        capture  = 1'b0;
        commit   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    load     = 1'b1;
                    state_nx = ld_cnt_zero ? ST_DONE : ST_READ;
                end
            end
            ST_READ: begin
                if (mem_valid) begin
                    capture  = 1'b1;
                    state_nx = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_valid) begin
                    commit = 1'b1;
                    if (last_elem)
                        state_nx = ST_DONE;
                    else if (stop_pend || single_step)
                        state_nx = ST_STOP;
                    else
                        state_nx = ST_READ;
                end
            end
            ST_DONE: state_nx = ST_IDLE;
            ST_STOP: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end
endmodule

// File: rtl/rep_copy_engine.sv
// Module: top of the interruptible repeated byte-copy engine.
// Copies in_cnt bytes from in_src to in_dst one element at a time and can stop
// at any element boundary with its registers committed, so a restart resumes.
// Assumes: memory returns exactly one mem_valid per request; start is ignored while busy.
module rep_copy_engine
    import rcopy_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] in_src,
    input  logic [AW-1:0] in_dst,
    input  logic [CW-1:0] in_cnt,
    input  logic          single_step,
    input  logic          irq_req,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    input  logic          mem_valid,
    output logic          busy,
    output logic          done,
    output logic          intr,
    output logic [AW-1:0] out_src,
    output logic [AW-1:0] out_dst,
    output logic [CW-1:0] out_cnt
);
    rcopy_state_e  state;
    logic          load, capture, commit;
    logic          ld_cnt_zero, last_elem, stop_pend, in_flight, clr_pend;
    logic [AW-1:0] cur_src, cur_dst;
    logic [CW-1:0] cur_cnt;
    logic [7:0]    byte_q;

    rcopy_arch_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .commit      (commit),
        .ld_src      (in_src),
        .ld_dst      (in_dst),
        .ld_cnt      (in_cnt),
        .cur_src     (cur_src),
        .cur_dst     (cur_dst),
        .cur_cnt     (cur_cnt),
        .ld_cnt_zero (ld_cnt_zero),
        .last_elem   (last_elem)
    );

    rcopy_irq_latch u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req   (irq_req),
        .in_flight (in_flight),
        .clear     (clr_pend),
        .pend_any  (stop_pend)
    );

    rcopy_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .ld_cnt_zero (ld_cnt_zero),
        .last_elem   (last_elem),
        .mem_valid   (mem_valid),
        .stop_pend   (stop_pend),
        .single_step (single_step),
        .state       (state),
        .load        (load),
        .capture     (capture),
        .commit      (commit)
    );

    // Hold the byte read from the source until it is written.
    always_ff @(posedge clk) begin
        if (!rst_n)
            byte_q <= '0;
        else if (capture)
            byte_q <= mem_rdata;
    end

    // Port decode from the sequencer state.
    always_comb begin
        in_flight = (state == ST_READ) || (state == ST_WRITE);
        clr_pend  = (state == ST_DONE) || (state == ST_STOP);
        mem_req   = in_flight;
        mem_we    = (state == ST_WRITE);
        mem_addr  = (state == ST_WRITE) ? cur_dst : cur_src;
        mem_wdata = byte_q;
        busy      = in_flight;
        done      = (state == ST_DONE);
        intr      = (state == ST_STOP);
        out_src   = cur_src;
        out_dst   = cur_dst;
        out_cnt   = cur_cnt;
    end
endmodule

// File: rtl/rcopy_chk.sv
// Module: property checker for rep_copy_engine, attached by bind.
// Assumes: rst_n is the synchronous active-low reset of the engine.
module rcopy_chk #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_valid,
    input logic          busy,
    input logic          done,
    input logic          intr,
    input logic [AW-1:0] out_src,
    input logic [AW-1:0] out_dst,
    input logic [CW-1:0] out_cnt
);
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);  // R1
    AST_READ_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_req && mem_we && mem_valid) && mem_req) |-> !mem_we);  // R2
    AST_CNT_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && (out_cnt != $past(out_cnt)))
            |-> ((out_cnt == $past(out_cnt) - CW'(1)) && $past(mem_valid && mem_we)));  // R3
    AST_PTR_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && (out_src != $past(out_src)))
            |-> ((out_src == $past(out_src) + AW'(1)) && (out_dst == $past(out_dst) + AW'(1))));  // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R4
    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_cnt == '0));  // R4
    AST_INTR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        intr |=> !intr);  // R6
    AST_INTR_LEAVES_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        intr |-> (out_cnt != '0));  // R8
    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && intr));  // R8
endmodule

bind rep_copy_engine rcopy_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_valid (mem_valid),
    .busy      (busy),
    .done      (done),
    .intr      (intr),
    .out_src   (out_src),
    .out_dst   (out_dst),
    .out_cnt   (out_cnt)
);

// File: tb/rep_copy_engine_bench.sv
`timescale 1ns/1ps
module rep_copy_engine_bench;
    localparam int AW  = 16;
    localparam int CW  = 16;
    localparam int LAT = 1;
    localparam int NV  = 6;

    typedef struct packed {
        logic [15:0] src;
        logic [15:0] dst;
        logic [15:0] cnt;
        logic        step;
        logic [7:0]  irq_at;
        logic        exp_intr;
        logic [15:0] esrc;
        logic [15:0] edst;
        logic [15:0] ecnt;
    } vec_t;

    // src, dst, cnt, step, irq_at(FF=none), expect intr, exp src, dst, cnt
    localparam vec_t VECS [NV] = '{
        '{16'd10, 16'd80,  16'd5, 1'b0, 8'hFF, 1'b0, 16'd15, 16'd85,  16'd0},
        '{16'd20, 16'd100, 16'd3, 1'b1, 8'hFF, 1'b1, 16'd21, 16'd101, 16'd2},
        '{16'd30, 16'd120, 16'd6, 1'b0, 8'd2,  1'b1, 16'd33, 16'd123, 16'd3},
        '{16'd40, 16'd140, 16'd2, 1'b0, 8'd1,  1'b0, 16'd42, 16'd142, 16'd0},
        '{16'd50, 16'd160, 16'd1, 1'b1, 8'hFF, 1'b0, 16'd51, 16'd161, 16'd0},
        '{16'd60, 16'd180, 16'd4, 1'b0, 8'd0,  1'b1, 16'd61, 16'd181, 16'd3}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] in_src = '0, in_dst = '0;
    logic [CW-1:0] in_cnt = '0;
    logic          single_step = 1'b0;
    logic          irq_auto = 1'b0, irq_manual = 1'b0;
    logic          mem_req, mem_we, busy, done, intr;
    logic [AW-1:0] mem_addr, out_src, out_dst;
    logic [CW-1:0] out_cnt;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = '0;
    logic          mem_valid = 1'b0;

    logic [7:0]    mem [256];
    logic          mem_init = 1'b0;
    int            lat_cnt = 0;
    int unsigned   rd_count = 0, wr_count = 0;
    int unsigned   irq_target = 32'hFFFF_FFFF, irq_fired = 32'hFFFF_FFFE;

    int checks = 0, failures = 0;
    logic got_intr;

    always #10 clk = ~clk;

    rep_copy_engine #(.AW(AW), .CW(CW)) u_rep_copy_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .in_src(in_src), .in_dst(in_dst),
        .in_cnt(in_cnt), .single_step(single_step), .irq_req(irq_auto | irq_manual),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_valid(mem_valid), .busy(busy), .done(done),
        .intr(intr), .out_src(out_src), .out_dst(out_dst), .out_cnt(out_cnt)
    );

    function automatic logic [7:0] init_byte(int a);
        return 8'((a * 7) + 3);
    endfunction

    // Memory model and interrupt injector, both on the falling edge.
    always @(negedge clk) begin
        if (!mem_init) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_byte(i);
            mem_init <= 1'b1;
        end
        irq_auto <= 1'b0;
        if (mem_req && !mem_we && !mem_valid && wr_count == irq_target && irq_fired != irq_target) begin
            irq_auto  <= 1'b1;
            irq_fired <= irq_target;
        end
        if (mem_valid) begin
            mem_valid <= 1'b0;
            lat_cnt   <= 0;
        end else if (mem_req) begin
            if (lat_cnt == LAT) begin
                mem_valid <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr[7:0]] <= mem_wdata;
                    wr_count <= wr_count + 1;
                end else begin
                    mem_rdata <= mem[mem_addr[7:0]];
                    rd_count <= rd_count + 1;
                end
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Start a copy and wait for done or intr; outputs sampled on falling edges.
    task automatic run_copy(input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                            input logic st, input logic [7:0] irq_at);
        int t;
        @(negedge clk);
        irq_target = (irq_at == 8'hFF) ? 32'hFFFF_FFFF : wr_count + irq_at;
        in_src = s; in_dst = d; in_cnt = c; single_step = st; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && !intr && t < 500) begin
            @(negedge clk);
            t++;
        end
        if (t >= 500) begin
            failures++;
            $display("FAIL watchdog run_copy actual=timeout expected=pulse");
        end
        got_intr = intr;
    endtask

    task automatic check_bytes(string tag, int s, int d, int n);
        for (int i = 0; i < n; i++)
            check_eq(tag, 32'(mem[(d + i) % 256]), 32'(init_byte(s + i)));
    endtask

    initial begin
        int steps;
        int unsigned rd0, wr0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check_eq("R1 busy", 32'(busy), 0);
        check_eq("R1 mem_req", 32'(mem_req), 0);
        check_eq("R1 done", 32'(done), 0);
        check_eq("R1 intr", 32'(intr), 0);
        rst_n = 1'b1;

        // Vector table walk: R2 R3 R4 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            run_copy(VECS[v].src, VECS[v].dst, VECS[v].cnt, VECS[v].step, VECS[v].irq_at);
            check_eq("R6/R7/R8 stop kind", 32'(got_intr), 32'(VECS[v].exp_intr));
            check_eq("R3 src", 32'(out_src), 32'(VECS[v].esrc));
            check_eq("R3 dst", 32'(out_dst), 32'(VECS[v].edst));
            check_eq("R3/R4 cnt", 32'(out_cnt), 32'(VECS[v].ecnt));
            check_bytes("R2 copied byte", VECS[v].src, VECS[v].dst, VECS[v].cnt - VECS[v].ecnt);
            if (VECS[v].exp_intr)
                check_eq("R6 byte beyond stop untouched", 32'(mem[VECS[v].edst[7:0]]),
                         32'(init_byte(VECS[v].edst)));
            @(negedge clk);
            check_eq("R4/R6 pulse lasts one cycle", 32'(done | intr), 0);
        end

        // R9: restart from the registers reported at the vector-3 stop
        run_copy(16'd33, 16'd123, 16'd3, 1'b0, 8'hFF);
        check_eq("R9 finishes with done", 32'(got_intr), 0);
        check_eq("R9 src", 32'(out_src), 36);
        check_eq("R9 cnt", 32'(out_cnt), 0);
        check_bytes("R9 full region", 30, 120, 6);

        // R5: zero-count start
        rd0 = rd_count; wr0 = wr_count;
        @(negedge clk);
        in_src = 16'd200; in_dst = 16'd210; in_cnt = 16'd0; single_step = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_eq("R5 done next cycle", 32'(done), 1);
        check_eq("R5 src unchanged", 32'(out_src), 200);
        check_eq("R5 dst unchanged", 32'(out_dst), 210);
        check_eq("R5 cnt unchanged", 32'(out_cnt), 0);
        repeat (3) @(negedge clk);
        check_eq("R5 no reads", rd_count - rd0, 0);
        check_eq("R5 no writes", wr_count - wr0, 0);

        // R10: interrupt while idle is dropped
        irq_manual = 1'b1;
        repeat (2) @(negedge clk);
        irq_manual = 1'b0;
        run_copy(16'd5, 16'd220, 16'd2, 1'b0, 8'hFF);
        check_eq("R10 idle irq ignored", 32'(got_intr), 0);
        check_eq("R10 cnt", 32'(out_cnt), 0);
        check_bytes("R10 bytes", 5, 220, 2);

        // R10: interrupt held from the start still lets one element move
        irq_manual = 1'b1;
        run_copy(16'd70, 16'd240, 16'd3, 1'b0, 8'hFF);
        irq_manual = 1'b0;
        check_eq("R10 stop after one element", 32'(got_intr), 1);
        check_eq("R10 cnt after one element", 32'(out_cnt), 2);

        // R7 R9: single-step restarts until the copy finishes
        steps = 0;
        run_copy(16'd70, 16'd230, 16'd4, 1'b1, 8'hFF);
        while (got_intr && steps < 10) begin
            steps++;
            check_eq("R7 one element per step", 32'(out_cnt), 32'(4 - steps));
            run_copy(out_src, out_dst, out_cnt, 1'b1, 8'hFF);
        end
        check_eq("R7 stop count", 32'(steps), 3);
        check_eq("R9 step chain ends at zero", 32'(out_cnt), 0);
        check_bytes("R9 step chain bytes", 70, 230, 4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Global watchdog.
    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog global actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule